// File: doc/BRIEF.md
# Three-Bank Interrupt Request Controller

This block gathers 96 interrupt sources into one request line for a processor. The sources form three banks of 32, and each bank is controlled through its own 32-byte register window. For every source the block holds three independent bits of configuration: a polarity-invert bit, an assert bit that admits the source at all, and an enable bit that lets an admitted request reach the request line. Each of the three bits is changed only through paired write-one-to-set and write-one-to-clear registers. As a result, software can change one source without a read-modify-write that might disturb its neighbours.

Banks 0 and 2 treat their inputs as levels: a request follows the polarity-corrected input for as long as the source is asserted. Bank 1 captures rising edges of the polarity-corrected input into sticky latches. Software releases these latches through a shared clear register. Software reads a raw view and a masked view of each bank. The request output is the registered OR of all masked bits.

The register bus is minimal: a byte address, a write strobe, 32 bits of write data, and read data that appears one cycle after the address.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Source n (0..95) is bit n mod 32 of bank n div 32. Bank b owns bytes 0x20*b..0x20*b+0x1C, and its registers sit at offsets 0x00 enable-set, 0x04 enable-clear, 0x08 invert-set, 0x0C invert-clear, 0x10 assert-set, 0x14 assert-clear, 0x18 raw status and 0x1C masked status.
- R2: A write to enable-set sets the enable bits where the data has ones, and a write to enable-clear clears them. Zero data bits leave bits unchanged, and reading enable-set returns the enable state.
- R3: Invert-set and invert-clear change the per-source invert bit in the same way, and invert-set reads it back. A request condition is the source input XOR its invert bit.
- R4: Assert-set and assert-clear change the per-source assert bit, and assert-set reads it back. A source whose assert bit is 0 shows 0 in raw and masked status, never drives the request line, and captures no edge.
- R5: Raw status (offset 0x18) shows the request state of every asserted source whatever its enable bit.
- R6: Masked status (offset 0x1C) equals raw status ANDed with the enable bits.
- R7: In bank 1, a rising edge of the polarity-corrected input of an asserted source sets a latch that holds after the input returns. Writing ones to the clear register at byte 0x60 clears the matching bank-1 latches. The clear register has no effect on banks 0 and 2.
- R8: In banks 0 and 2 the raw bit follows the polarity-corrected input while the source is asserted, with nothing held.
- R9: After reset every enable, invert, assert and edge-latch bit is 0, read data is 0 and the request line is low.
- R10: The request output is the OR of all 96 masked bits, registered once: it changes on the clock edge after the masked state changes.
- R11: If a new bank-1 edge and a clear write hit the same bit on the same clock edge, the latch ends up set.
- R12: Read data reflects the register addressed in the previous cycle. Write-only offsets, misaligned addresses and addresses above 0x60 read 0. Writes to addresses above 0x60 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the address |
| src_in | input | 96 | Interrupt source inputs, source n on bit n |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the bound checker verifies several relations. No unasserted source shows raw status. Masked status stays within both raw status and enable. The request line follows the OR of masked status one edge later. Bank-1 latches never drop without a write, an enable-clear write empties the bits it names, and writes above the clear register leave the configuration alone. The bench scenarios show the remaining behaviours: the address map and read latency, polarity inversion turning a falling input into a captured edge, an edge arriving while a source is unasserted being lost, the clear register leaving level banks untouched, the collision between an edge and a clear, and the return to the reset state in the middle of a run.

// File: rtl/icb_pkg.sv
`timescale 1ns/1ps
package icb_pkg;
  // Each bank owns a 32-byte window of eight word registers.
  localparam int unsigned WIN_LSB  = 5;
  localparam int unsigned KIND_LSB = 2;

  typedef enum logic [2:0] {
    RK_EN_SET  = 3'd0,
    RK_EN_CLR  = 3'd1,
    RK_INV_SET = 3'd2,
    RK_INV_CLR = 3'd3,
    RK_ARM_SET = 3'd4,
    RK_ARM_CLR = 3'd5,
    RK_RAW     = 3'd6,
    RK_MST     = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic inv_set;
    logic inv_clr;
    logic arm_set;
    logic arm_clr;
  } bank_wr_t;
endpackage

// File: rtl/icb_addr_dec.sv
`timescale 1ns/1ps
module icb_addr_dec
  import icb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned BIDX_W   = ADDR_W - WIN_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output bank_wr_t          wr_strb [NUM_BANKS],
  output logic              clr_we,
  output logic              rd_hit,
  output logic [BIDX_W-1:0] rd_bank,
  output reg_kind_e         rd_kind
);
  // The shared edge-clear register sits just past the last bank window.
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_BANKS << WIN_LSB);

  logic aligned;
  logic sel;

  always_comb begin
    aligned = (addr[KIND_LSB-1:0] == '0);
    rd_bank = addr[ADDR_W-1:WIN_LSB];
    rd_kind = reg_kind_e'(addr[WIN_LSB-1:KIND_LSB]);
    rd_hit  = aligned && (32'(rd_bank) < NUM_BANKS);
    clr_we  = wr_en && (addr == CLR_ADDR);
    for (int b = 0; b < NUM_BANKS; b++) begin
      sel = wr_en && rd_hit && (rd_bank == BIDX_W'(b));
      wr_strb[b].en_set  = sel && (rd_kind == RK_EN_SET);
      wr_strb[b].en_clr  = sel && (rd_kind == RK_EN_CLR);
      wr_strb[b].inv_set = sel && (rd_kind == RK_INV_SET);
      wr_strb[b].inv_clr = sel && (rd_kind == RK_INV_CLR);
      wr_strb[b].arm_set = sel && (rd_kind == RK_ARM_SET);
      wr_strb[b].arm_clr = sel && (rd_kind == RK_ARM_CLR);
    end
  end
endmodule

// File: rtl/icb_setclr_reg.sv
`timescale 1ns/1ps
module icb_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         upd;

  always_comb begin
    upd   = set_we | clr_we;
    q_nxt = q;
    if (set_we) q_nxt = q_nxt | wdata;
    if (clr_we) q_nxt = q_nxt & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/icb_src_stage.sv
`timescale 1ns/1ps
module icb_src_stage #(
  parameter int unsigned W    = 32,
  parameter bit          EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] arm,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] raw
);
  logic [W-1:0] pol;

  always_comb pol = src ^ inv;

  generate
    if (EDGE) begin : g_edge
      logic [W-1:0] prev_q;
      logic [W-1:0] lat_q;
      logic [W-1:0] lat_nxt;
      logic [W-1:0] rise;

      always_comb begin
        rise    = pol & ~prev_q;
        lat_nxt = lat_q;
        if (clr_we) lat_nxt = lat_nxt & ~clr_mask;
        // A fresh edge wins over a clear on the same edge.
        lat_nxt = lat_nxt | (rise & arm);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= '0;
          lat_q  <= '0;
        end else begin
          prev_q <= pol;
          lat_q  <= lat_nxt;
        end
      end

      assign raw = lat_q & arm;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{clk, rst_n, clr_we, clr_mask};
      assign raw = pol & arm;
    end
  endgenerate
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
  import icb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned EDGE_BANK = 1,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int unsigned BIDX_W   = ADDR_W - WIN_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [BANK_W-1:0]  wdata,
  output logic [BANK_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  bank_wr_t          wr_strb [NUM_BANKS];
  logic              clr_we;
  logic              rd_hit;
  logic [BIDX_W-1:0] rd_bank;
  reg_kind_e         rd_kind;

  icb_addr_dec #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_strb (wr_strb),
    .clr_we  (clr_we),
    .rd_hit  (rd_hit),
    .rd_bank (rd_bank),
    .rd_kind (rd_kind)
  );

  logic [BANK_W-1:0]  en_q  [NUM_BANKS];
  logic [BANK_W-1:0]  inv_q [NUM_BANKS];
  logic [BANK_W-1:0]  arm_q [NUM_BANKS];
  logic [BANK_W-1:0]  raw_w [NUM_BANKS];
  logic [BANK_W-1:0]  mst_w [NUM_BANKS];
  logic [NUM_SRC-1:0] en_all;
  logic [NUM_SRC-1:0] inv_all;
  logic [NUM_SRC-1:0] arm_all;
  logic [NUM_SRC-1:0] raw_all;
  logic [NUM_SRC-1:0] mst_all;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      icb_setclr_reg #(.W(BANK_W)) u_en (
        .clk    (clk),
        .rst_n  (rst_sn),
        .set_we (wr_strb[b].en_set),
        .clr_we (wr_strb[b].en_clr),
        .wdata  (wdata),
        .q      (en_q[b])
      );

      icb_setclr_reg #(.W(BANK_W)) u_inv (
        .clk    (clk),
        .rst_n  (rst_sn),
        .set_we (wr_strb[b].inv_set),
        .clr_we (wr_strb[b].inv_clr),
        .wdata  (wdata),
        .q      (inv_q[b])
      );

      icb_setclr_reg #(.W(BANK_W)) u_arm (
        .clk    (clk),
        .rst_n  (rst_sn),
        .set_we (wr_strb[b].arm_set),
        .clr_we (wr_strb[b].arm_clr),
        .wdata  (wdata),
        .q      (arm_q[b])
      );

      icb_src_stage #(
        .W    (BANK_W),
        .EDGE (b == EDGE_BANK)
      ) u_src (
        .clk      (clk),
        .rst_n    (rst_sn),
        .src      (src_in[b*BANK_W +: BANK_W]),
        .inv      (inv_q[b]),
        .arm      (arm_q[b]),
        .clr_we   (clr_we),
        .clr_mask (wdata),
        .raw      (raw_w[b])
      );

      assign mst_w[b] = raw_w[b] & en_q[b];

      assign en_all [b*BANK_W +: BANK_W] = en_q[b];
      assign inv_all[b*BANK_W +: BANK_W] = inv_q[b];
      assign arm_all[b*BANK_W +: BANK_W] = arm_q[b];
      assign raw_all[b*BANK_W +: BANK_W] = raw_w[b];
      assign mst_all[b*BANK_W +: BANK_W] = mst_w[b];
    end
  endgenerate

  // Read multiplexer and request reduction.
  logic [BANK_W-1:0] rd_nxt;
  logic              irq_nxt;

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_hit && (rd_bank == BIDX_W'(b))) begin
        case (rd_kind)
          RK_EN_SET:  rd_nxt = en_q[b];
          RK_INV_SET: rd_nxt = inv_q[b];
          RK_ARM_SET: rd_nxt = arm_q[b];
          RK_RAW:     rd_nxt = raw_w[b];
          RK_MST:     rd_nxt = mst_w[b];
          default:    rd_nxt = '0;
        endcase
      end
    end
    irq_nxt = |mst_all;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_nxt;
      irq     <= irq_nxt;
    end
  end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
`timescale 1ns/1ps
module banked_irq_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned EDGE_BANK = 1,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
  input logic               clk,
  input logic               rst_sn,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [BANK_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] inv_all,
  input logic [NUM_SRC-1:0] arm_all,
  input logic [NUM_SRC-1:0] raw_all,
  input logic [NUM_SRC-1:0] mst_all,
  input logic               irq
);
  localparam logic [ADDR_W-1:0] CLR_ADDR    = ADDR_W'(NUM_BANKS << 5);
  localparam logic [ADDR_W-1:0] EN_CLR_B0   = ADDR_W'(4);

  logic [BANK_W-1:0] edge_raw;
  assign edge_raw = raw_all[EDGE_BANK*BANK_W +: BANK_W];

  // R4
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (raw_all & ~arm_all) == '0);

  // R6
  masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((mst_all & ~en_all) == '0) && ((mst_all & ~raw_all) == '0));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (|mst_all) |=> irq);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(|mst_all) |=> !irq);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_en |=> ((edge_raw & $past(edge_raw)) == $past(edge_raw)));

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr == EN_CLR_B0) |=> ((en_all[BANK_W-1:0] & $past(wdata)) == '0));

  // R12
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr > CLR_ADDR) |=> ($stable(en_all) && $stable(inv_all) && $stable(arm_all)));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .EDGE_BANK (EDGE_BANK)
) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .addr    (addr),
  .wr_en   (wr_en),
  .wdata   (wdata),
  .en_all  (en_all),
  .inv_all (inv_all),
  .arm_all (arm_all),
  .raw_all (raw_all),
  .mst_all (mst_all),
  .irq     (irq)
);

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctrl;
  localparam logic [3:0] OP_WR  = 4'd1;
  localparam logic [3:0] OP_RD  = 4'd2;
  localparam logic [3:0] OP_SRC = 4'd3;
  localparam logic [3:0] OP_IRQ = 4'd4;
  localparam int NV = 60;

  function automatic logic [79:0] mk(input logic [3:0] op, input logic [7:0] a,
                                     input logic [31:0] d, input logic [31:0] e,
                                     input logic [3:0] r);
    return {op, a, d, e, r};
  endfunction

  // Vector: operation, address or bank, data, expected, requirement number.
  localparam logic [79:0] VECS [NV] = '{
    mk(OP_RD,  8'h00, 32'h0,        32'h0,        4'd9),   // R9 enable empty
    mk(OP_RD,  8'h38, 32'h0,        32'h0,        4'd9),   // R9 latch empty
    mk(OP_WR,  8'h00, 32'h000000F0, 32'h0,        4'd2),   // R2
    mk(OP_WR,  8'h04, 32'h00000030, 32'h0,        4'd2),   // R2
    mk(OP_RD,  8'h00, 32'h0,        32'h000000C0, 4'd2),   // R2
    mk(OP_RD,  8'h04, 32'h0,        32'h0,        4'd12),  // R12 write-only
    mk(OP_SRC, 8'h00, 32'h00000080, 32'h0,        4'd4),
    mk(OP_RD,  8'h18, 32'h0,        32'h0,        4'd4),   // R4 not asserted
    mk(OP_IRQ, 8'h00, 32'h0,        32'h0,        4'd4),   // R4
    mk(OP_WR,  8'h10, 32'h00000180, 32'h0,        4'd4),
    mk(OP_RD,  8'h10, 32'h0,        32'h00000180, 4'd4),   // R4 readback
    mk(OP_RD,  8'h18, 32'h0,        32'h00000080, 4'd8),   // R8
    mk(OP_RD,  8'h1C, 32'h0,        32'h00000080, 4'd6),   // R6
    mk(OP_IRQ, 8'h00, 32'h0,        32'h1,        4'd10),  // R10
    mk(OP_SRC, 8'h00, 32'h00000100, 32'h0,        4'd8),
    mk(OP_RD,  8'h18, 32'h0,        32'h00000100, 4'd5),   // R5
    mk(OP_RD,  8'h1C, 32'h0,        32'h0,        4'd6),   // R6
    mk(OP_IRQ, 8'h00, 32'h0,        32'h0,        4'd8),   // R8
    mk(OP_WR,  8'h08, 32'h00000200, 32'h0,        4'd3),
    mk(OP_RD,  8'h08, 32'h0,        32'h00000200, 4'd3),   // R3
    mk(OP_WR,  8'h10, 32'h00000200, 32'h0,        4'd3),
    mk(OP_RD,  8'h18, 32'h0,        32'h00000300, 4'd3),   // R3 inverted low
    mk(OP_WR,  8'h0C, 32'h00000200, 32'h0,        4'd3),
    mk(OP_RD,  8'h08, 32'h0,        32'h0,        4'd3),   // R3
    mk(OP_RD,  8'h18, 32'h0,        32'h00000100, 4'd3),   // R3
    mk(OP_WR,  8'h14, 32'h00000100, 32'h0,        4'd4),
    mk(OP_RD,  8'h18, 32'h0,        32'h0,        4'd4),   // R4
    mk(OP_WR,  8'h50, 32'h80000000, 32'h0,        4'd1),
    mk(OP_WR,  8'h40, 32'h80000000, 32'h0,        4'd1),
    mk(OP_SRC, 8'h02, 32'h80000000, 32'h0,        4'd1),
    mk(OP_RD,  8'h5C, 32'h0,        32'h80000000, 4'd1),   // R1 source 95
    mk(OP_RD,  8'h3C, 32'h0,        32'h0,        4'd1),   // R1
    mk(OP_IRQ, 8'h00, 32'h0,        32'h1,        4'd1),   // R1
    mk(OP_WR,  8'h44, 32'h80000000, 32'h0,        4'd2),
    mk(OP_IRQ, 8'h00, 32'h0,        32'h0,        4'd2),   // R2
    mk(OP_SRC, 8'h02, 32'h0,        32'h0,        4'd8),
    mk(OP_WR,  8'h30, 32'h00000001, 32'h0,        4'd7),
    mk(OP_WR,  8'h20, 32'h00000001, 32'h0,        4'd7),
    mk(OP_SRC, 8'h01, 32'h00000001, 32'h0,        4'd7),
    mk(OP_SRC, 8'h01, 32'h0,        32'h0,        4'd7),
    mk(OP_RD,  8'h38, 32'h0,        32'h00000001, 4'd7),   // R7 held
    mk(OP_IRQ, 8'h00, 32'h0,        32'h1,        4'd7),   // R7
    mk(OP_WR,  8'h60, 32'h00000001, 32'h0,        4'd7),
    mk(OP_RD,  8'h38, 32'h0,        32'h0,        4'd7),   // R7 cleared
    mk(OP_IRQ, 8'h00, 32'h0,        32'h0,        4'd7),   // R7
    mk(OP_WR,  8'h64, 32'hFFFFFFFF, 32'h0,        4'd12),
    mk(OP_RD,  8'h64, 32'h0,        32'h0,        4'd12),  // R12
    mk(OP_RD,  8'h00, 32'h0,        32'h000000C0, 4'd12),  // R12 untouched
    mk(OP_WR,  8'h28, 32'h00000002, 32'h0,        4'd3),
    mk(OP_WR,  8'h30, 32'h00000002, 32'h0,        4'd4),
    mk(OP_RD,  8'h38, 32'h0,        32'h0,        4'd4),   // R4 edge lost
    mk(OP_SRC, 8'h01, 32'h00000002, 32'h0,        4'd3),
    mk(OP_SRC, 8'h01, 32'h0,        32'h0,        4'd3),
    mk(OP_RD,  8'h38, 32'h0,        32'h00000002, 4'd3),   // R3 falling input
    mk(OP_WR,  8'h60, 32'h00000002, 32'h0,        4'd7),
    mk(OP_RD,  8'h38, 32'h0,        32'h0,        4'd7),   // R7
    mk(OP_SRC, 8'h00, 32'h00000080, 32'h0,        4'd7),
    mk(OP_WR,  8'h60, 32'h00000080, 32'h0,        4'd7),
    mk(OP_RD,  8'h18, 32'h0,        32'h00000080, 4'd7),   // R7 level bank
    mk(OP_SRC, 8'h00, 32'h0,        32'h0,        4'd8)
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic [95:0] src_in;
  logic        irq;

  int n_chk;
  int n_fail;

  banked_irq_ctrl u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_data (rd_data),
    .src_in  (src_in),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    addr   = '0;
    wr_en  = 1'b0;
    wdata  = '0;
    src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(9, 32'(irq), 32'h0);  // R9

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic [3:0]  r;
      {op, a, d, e, r} = VECS[i];
      case (op)
        OP_WR:  begin addr = a; wdata = d; wr_en = 1'b1; end
        OP_RD:  addr = a;
        OP_SRC: src_in[a[1:0]*32 +: 32] = d;
        default: ;
      endcase
      @(negedge clk);
      wr_en = 1'b0;
      if (op == OP_RD)  check(int'(r), rd_data, e);
      if (op == OP_IRQ) check(int'(r), 32'(irq), e);
    end

    // R10: request is registered, not combinational.
    src_in[7] = 1'b1;
    #1;
    check(10, 32'(irq), 32'h0);
    @(negedge clk);
    check(10, 32'(irq), 32'h1);
    src_in[7] = 1'b0;
    @(negedge clk);
    check(10, 32'(irq), 32'h0);

    // R11: edge and clear on the same bit in the same cycle.
    src_in[33] = 1'b1;
    @(negedge clk);
    src_in[33] = 1'b0;
    addr  = 8'h60;
    wdata = 32'h2;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    read_chk(11, 8'h38, 32'h2);
    addr  = 8'h60;
    wdata = 32'h2;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    read_chk(11, 8'h38, 32'h0);

    // R9: reset in the middle of a run.
    src_in[7] = 1'b1;
    repeat (2) @(negedge clk);
    check(9, 32'(irq), 32'h1);
    rst_n = 1'b0;
    #1;
    check(9, 32'(irq), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk(9, 8'h00, 32'h0);
    read_chk(9, 8'h10, 32'h0);
    read_chk(9, 8'h28, 32'h0);
    check(9, 32'(irq), 32'h0);
    src_in = '0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule